// File: doc/BRIEF.md
# Extend and Bit-Test Execution Slice

This block is one execution slice of a 32-bit processor core. It owns an eight-entry register file of low registers and a four-bit condition flag register. It carries out four single-cycle operations: sign extension of a halfword, zero extension of a byte, a flag-only bitwise test, and a load of an immediate word. The load operation is how values reach the registers.

Each operation is selected by a 2-bit opcode. It names registers with 3-bit indices and is qualified by a valid strobe. The extend and load results appear combinationally on the write-back port in the same cycle, together with a write enable. The destination register takes the result on the next rising clock edge. The test operation ANDs two registers and records only the sign and zero of the result in the flags. The other two flags keep their values, and no register is written.

Top module: `bitx_unit`

## Requirements
- R1: A synchronous reset sets all eight registers and all four flags to 0. Flags are packed as flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V.
- R2: With op=2'b10 (test), the next flags have N equal to bit 31 of (reg[rn] & reg[rm]), and Z equal to 1 exactly when that AND is all zeros.
- R3: The test operation writes no register and holds wb_en low. Whenever wb_en is low, wb_data is 0.
- R4: The test operation leaves C and V at their previous values.
- R5: With op=2'b00 (sign-extend halfword), wb_data is reg[rm][15:0] with bit 15 copied into bits 31:16, and reg[rd] takes that value.
- R6: With op=2'b01 (zero-extend byte), wb_data is reg[rm][7:0] with bits 31:8 cleared, and reg[rd] takes that value.
- R7: An operation other than the test leaves all four flags unchanged.
- R8: With op=2'b11 (load immediate), wb_data equals imm, and reg[rd] takes it.
- R9: While valid is low, wb_en is low and no register or flag changes.
- R10: Every operation completes in one cycle. A result written at one edge is the operand seen by an operation issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Operation strobe |
| op | input | 2 | Opcode: 00 sign-extend halfword, 01 zero-extend byte, 10 test, 11 load immediate |
| rd | input | 3 | Destination register index |
| rn | input | 3 | First test operand index |
| rm | input | 3 | Second test operand / extend source index |
| imm | input | 32 | Immediate word for load |
| wb_data | output | 32 | Write-back result, 0 when wb_en is low |
| wb_en | output | 1 | Write-back enable |
| flags | output | 4 | Condition flags {N,Z,C,V} |

## Verification
The properties assume that op, valid and the indices are settled before each rising edge. They also assume that reset is held for at least one edge before any operation counts. The bench drives every input at the falling edge and keeps rst high through two rising edges, so both assumptions hold. The flag properties compare only against values registered after reset, so they never depend on state from before the first edge. The sweeps cover every destination and source index pair for each opcode, including runs with valid held low.

// File: rtl/bitx_unit.sv
module bitx_unit #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic [1:0]      op,
  input  logic [IW-1:0]   rd,
  input  logic [IW-1:0]   rn,
  input  logic [IW-1:0]   rm,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] wb_data,
  output logic            wb_en,
  output logic [3:0]      flags
);
  localparam logic [1:0] OP_SXH = 2'b00;
  localparam logic [1:0] OP_UXB = 2'b01;
  localparam logic [1:0] OP_TST = 2'b10;
  localparam logic [1:0] OP_LDI = 2'b11;

  logic [XLEN-1:0] rf [NREG];
  logic [XLEN-1:0] src_n, src_m, conj, res;
  logic [3:0]      flg;

  assign src_n = rf[rn];
  assign src_m = rf[rm];
  assign conj  = src_n & src_m;

  always_comb begin
    case (op)
      OP_SXH:  res = {{(XLEN-16){src_m[15]}}, src_m[15:0]};
      OP_UXB:  res = {{(XLEN-8){1'b0}}, src_m[7:0]};
      OP_LDI:  res = imm;
      default: res = '0;
    endcase
  end

  assign wb_en   = valid && (op != OP_TST);
  assign wb_data = wb_en ? res : '0;
  assign flags   = flg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      flg <= '0;
    end else if (valid) begin
      if (wb_en) rf[rd] <= res;
      if (op == OP_TST) flg <= {conj[XLEN-1], ~|conj, flg[1:0]};
    end
  end
endmodule

module bitx_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            valid,
  input logic [1:0]      op,
  input logic [XLEN-1:0] wb_data,
  input logic            wb_en,
  input logic [3:0]      flags
);
  p_tst_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 2'b10) |-> !wb_en);
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !wb_en |-> wb_data == '0);
  p_cv_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 2'b10) |=> flags[1:0] == $past(flags[1:0]));
  p_sxh_sign_r5: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 2'b00) |-> wb_data[XLEN-1:16] == {(XLEN-16){wb_data[15]}});
  p_uxb_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 2'b01) |-> wb_data[XLEN-1:8] == '0);
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && op != 2'b10) |=> $stable(flags));
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !valid |-> !wb_en);
  p_idle_flags_r9: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(flags));
endmodule

bind bitx_unit bitx_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .op(op),
  .wb_data(wb_data), .wb_en(wb_en), .flags(flags)
);

// File: tb/bitx_unit_test.sv
module bitx_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, valid;
  logic [1:0]  op;
  logic [2:0]  rd, rn, rm;
  logic [31:0] imm, wb_data;
  logic        wb_en;
  logic [3:0]  flags;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_rf [8];
  logic [3:0]  m_fl;
  logic [31:0] seed = 32'h1234_5677;

  bitx_unit uut (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .rd(rd), .rn(rn), .rm(rm),
    .imm(imm), .wb_data(wb_data), .wb_en(wb_en), .flags(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (act hung, exp done)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextv();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed ^ {seed[15:0], seed[31:16]};
  endfunction

  task automatic run(input logic [1:0] o, input logic [2:0] d, input logic [2:0] n,
                     input logic [2:0] m, input logic [31:0] im, input bit v, input string tag);
    logic [31:0] exp_wb, a;
    logic        exp_en;
    @(negedge clk);
    op = o; rd = d; rn = n; rm = m; imm = im; valid = v;
    #1;
    exp_en = v && (o != 2'b10);
    case (o)
      2'b00:   exp_wb = {{16{m_rf[m][15]}}, m_rf[m][15:0]};
      2'b01:   exp_wb = {24'h0, m_rf[m][7:0]};
      2'b11:   exp_wb = im;
      default: exp_wb = 32'h0;
    endcase
    if (!exp_en) exp_wb = 32'h0;
    check(tag, wb_data, exp_wb);
    check(tag, {31'h0, wb_en}, {31'h0, exp_en});
    a = m_rf[n] & m_rf[m];
    @(posedge clk);
    #1;
    if (exp_en) m_rf[d] = exp_wb;
    if (v && o == 2'b10) begin
      m_fl = {a[31], a == 32'h0, m_fl[1:0]};
      check("R2", {30'h0, flags[3:2]}, {30'h0, m_fl[3:2]});
      check("R4", {30'h0, flags[1:0]}, {30'h0, m_fl[1:0]});
    end else begin
      check(v ? "R7" : "R9", {28'h0, flags}, {28'h0, m_fl});
    end
    valid = 1'b0;
  endtask

  initial begin
    logic [31:0] corners [8];
    corners[0] = 32'h0000_8000; corners[1] = 32'h0000_7FFF;
    corners[2] = 32'h0000_0080; corners[3] = 32'h0000_00FF;
    corners[4] = 32'hFFFF_FFFF; corners[5] = 32'h0000_0000;
    corners[6] = 32'h8000_0000; corners[7] = 32'h7FFF_FF7F;
    rst = 1'b1; valid = 1'b0; op = 2'b00; rd = 0; rn = 0; rm = 0; imm = 0;
    for (int i = 0; i < 8; i++) m_rf[i] = 32'h0;
    m_fl = 4'h0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", {28'h0, flags}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int r = 0; r < 8; r++) run(2'b00, 3'(r), 3'(r), 3'(r), 32'h0, 1'b1, "R1");

    for (int round = 0; round < 6; round++) begin
      for (int r = 0; r < 8; r++)
        run(2'b11, 3'(r), 3'd0, 3'd0, (round == 0) ? corners[r] : nextv(), 1'b1, "R8");
      for (int n = 0; n < 8; n++)
        for (int m = 0; m < 8; m++)
          run(2'b10, 3'(nextv() & 7), 3'(n), 3'(m), nextv(), 1'b1, "R3");
      for (int d = 0; d < 8; d++)
        for (int m = 0; m < 8; m++) begin
          run(2'b00, 3'(d), 3'(nextv() & 7), 3'(m), nextv(), 1'b1, "R5");
          run(2'b01, 3'(d), 3'(nextv() & 7), 3'(m), nextv(), 1'b1, "R6");
        end
      for (int k = 0; k < 16; k++)
        run(2'(nextv() & 3), 3'(k & 7), 3'(nextv() & 7), 3'(nextv() & 7), nextv(), 1'b0, "R9");
    end

    run(2'b11, 3'd1, 3'd0, 3'd0, 32'h0000_8001, 1'b1, "R10");
    run(2'b00, 3'd2, 3'd0, 3'd1, 32'h0, 1'b1, "R10");
    check("R10", m_rf[2], 32'hFFFF_8001);
    run(2'b10, 3'd5, 3'd2, 3'd2, 32'h0, 1'b1, "R3");
    check("R2", {28'h0, flags}, 32'h8);
    run(2'b11, 3'd3, 3'd0, 3'd0, 32'h7FFF_0000, 1'b1, "R8");
    run(2'b11, 3'd4, 3'd0, 3'd0, 32'h0000_FFFF, 1'b1, "R8");
    run(2'b10, 3'd3, 3'd3, 3'd4, 32'h0, 1'b1, "R3");
    check("R2", {28'h0, flags}, 32'h4);
    run(2'b00, 3'd6, 3'd0, 3'd3, 32'h0, 1'b1, "R3");
    check("R3", m_rf[6], 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule